// File: doc/BRIEF.md
# Channel-Status Transmit Sequencer

This block stores one 192-bit channel-status block for a digital audio transmitter and supplies one C bit per frame to the framer that builds the output subframes. The block lives in six 32-bit words, numbered 0 to 5 and written through a simple write port. Once both enables are set, the sequencer waits for a frame whose tick comes with the block-start flag, which marks the frame carrying the block preamble. It then walks the page one bit per frame: least significant bit first within a word, words in ascending order, and back to word 0 after bit 31 of word 5. The framer reads the same C value for both subframes of a frame.

A word is copied into an internal shifter at the frame that needs its first bit. Software can therefore rewrite a word while it is being sent, and the new value goes out on the next pass. A busy flag shows that the block is being sent. It rises when word 0 is loaded and falls when word 5 is loaded. It also falls at the first frame tick after either enable has cleared.

The controller has three states. ST_IDLE means disabled. ST_ARMED means both enables are set and the sequencer is waiting for a block start. ST_SEND means bits are being sent. The transitions are as follows. IDLE goes to ARMED when both enables are set. IDLE or ARMED goes to SEND on a frame tick with block start while enabled. ARMED goes back to IDLE when an enable drops. SEND goes to IDLE on a frame tick while an enable is low. SEND stays in SEND on every other tick, either stepping to the next bit or, on a block start, realigning to word 0.

Top module: `cs_tx_seq`

## Requirements
- R1: Six page words hold the block. A write with `wr_en` high and `wr_addr` 0 to 5 replaces that whole word. Word 0 holds bits 0 to 31 of the block and word 5 holds bits 160 to 191.
- R2: `c_bit` changes only in the cycle after a `frame_tick` pulse, or when `cs_en` changes. It holds one value for the whole frame, so both subframes carry the same bit.
- R3: A `frame_tick` with `block_start` high, while `tx_en` and `cs_en` are both high, loads word 0. From the next cycle `c_bit` shows bit 0 of word 0. Enabled ticks without a block start, seen before the first block start, leave `c_bit` at 0.
- R4: Each later tick advances one bit. Bits go LSB to MSB within a word and words go 0,1,2,3,4,5. After bit 31 of word 5 the sequence wraps to bit 0 of word 0 without needing a block start.
- R5: A tick with `block_start` in the middle of a block restarts the sequence at bit 0 of word 0.
- R6: `cs_busy` rises in the cycle after word 0 is loaded, and it is high only while sending.
- R7: `cs_busy` falls in the cycle after word 5 is loaded. It stays low for the 32 frames of word 5 and rises again at the wrap to word 0.
- R8: A tick while `tx_en` or `cs_en` is low stops the sequence. `cs_busy` and `c_bit` go to 0 in the next cycle. When an enable clears between ticks, `cs_busy` holds until that tick.
- R9: While `cs_en` is low, `c_bit` is 0 in the same cycle.
- R10: A word is captured at its load. A write to that word in the load cycle or later takes effect on the next pass. A write made before the load cycle is sent in the current pass.
- R11: After reset, `c_bit` and `cs_busy` are 0 and all page words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| wr_en | input | 1 | Page word write strobe |
| wr_addr | input | 3 | Page word index (0 to 5) |
| wr_data | input | 32 | Page word write data |
| frame_tick | input | 1 | One-cycle pulse at each frame start |
| block_start | input | 1 | Qualifies a tick as the block-preamble frame |
| tx_en | input | 1 | Transmitter enable |
| cs_en | input | 1 | Channel-status enable |
| c_bit | output | 1 | C bit for the current frame |
| cs_busy | output | 1 | Block is being sent |

## Verification
A page write and the load of the same word into the shifter can fall on one clock edge, and this case decides which value goes out. The bench writes word 0 in the very tick that wraps back to it, and writes other words in the tick that loads them and in gaps between ticks. It then checks that the shifted bits follow the value held before the write on this pass and the new value on the next pass. The bench also drops `cs_en` and `tx_en` between ticks, so that the end-of-frame stop and the busy release at the word-5 load are each judged against the bench's frame-level model.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } cs_state_e;
endpackage

// File: rtl/cs_page_regs.sv
module cs_page_regs #(
    parameter int WORDS  = 6,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] page [WORDS];

    // One register per word; only in-range addresses decode.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page[g] <= '0;
            end else if (wr_en && (wr_addr == IDX_W'(g))) begin
                page[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_idx) < WORDS) begin
            rd_word = page[rd_idx];
        end
    end
endmodule

// File: rtl/cs_shifter.sv
module cs_shifter #(
    parameter int WORDS  = 6,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_first,
    input  logic              step,
    input  logic [WORD_W-1:0] page_word,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              ld_strobe,
    output logic              c_raw
);
    logic [WORD_W-1:0] sh_q;
    logic [BIT_W-1:0]  bit_q;
    logic [IDX_W-1:0]  word_q;
    logic              last_bit;
    logic [IDX_W-1:0]  next_word;

    assign last_bit  = (bit_q == BIT_W'(WORD_W - 1));
    assign next_word = (word_q == IDX_W'(WORDS - 1)) ? '0 : word_q + 1'b1;
    assign rd_idx    = load_first ? '0 : next_word;
    assign ld_strobe = load_first | (step & last_bit);
    assign c_raw     = sh_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            word_q <= '0;
        end else if (ld_strobe) begin
            sh_q   <= page_word;
            bit_q  <= '0;
            word_q <= rd_idx;
        end else if (step) begin
            sh_q   <= sh_q >> 1;
            bit_q  <= bit_q + 1'b1;
        end
    end
endmodule

// File: rtl/cs_fsm.sv
module cs_fsm
    import cs_seq_pkg::*;
#(
    parameter int WORDS  = 6,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             block_start,
    input  logic             tx_en,
    input  logic             cs_en,
    input  logic             ld_strobe,
    input  logic [IDX_W-1:0] ld_idx,
    output cs_state_e        state,
    output logic             load_first,
    output logic             step,
    output logic             busy
);
    cs_state_e state_d;
    logic      en;

    assign en         = tx_en & cs_en;
    assign load_first = frame_tick & en & block_start;
    assign step       = frame_tick & en & ~block_start & (state == ST_SEND);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (load_first) state_d = ST_SEND;
                      else if (en)    state_d = ST_ARMED;
            ST_ARMED: if (load_first) state_d = ST_SEND;
                      else if (!en)   state_d = ST_IDLE;
            ST_SEND:  if (frame_tick && !en) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Output register: busy follows word loads and end-of-frame stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (frame_tick && !en) begin
            busy <= 1'b0;
        end else if (ld_strobe) begin
            if (ld_idx == '0)                       busy <= 1'b1;
            else if (ld_idx == IDX_W'(WORDS - 1))   busy <= 1'b0;
        end
    end
endmodule

// File: rtl/cs_tx_seq.sv
module cs_tx_seq
    import cs_seq_pkg::*;
#(
    parameter int WORDS  = 6,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_tick,
    input  logic              block_start,
    input  logic              tx_en,
    input  logic              cs_en,
    output logic              c_bit,
    output logic              cs_busy
);
    cs_state_e         state;
    logic              load_first, step, ld_strobe, c_raw;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] page_word;

    cs_page_regs #(.WORDS(WORDS), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_word(page_word)
    );

    cs_shifter #(.WORDS(WORDS), .WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_first(load_first), .step(step),
        .page_word(page_word), .rd_idx(rd_idx), .ld_strobe(ld_strobe),
        .c_raw(c_raw)
    );

    cs_fsm #(.WORDS(WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .block_start(block_start), .tx_en(tx_en), .cs_en(cs_en),
        .ld_strobe(ld_strobe), .ld_idx(rd_idx), .state(state),
        .load_first(load_first), .step(step), .busy(cs_busy)
    );

    assign c_bit = (state == ST_SEND) & cs_en & c_raw;
endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk
    import cs_seq_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      frame_tick,
    input logic      tx_en,
    input logic      cs_en,
    input logic      c_bit,
    input logic      cs_busy,
    input cs_state_e state
);
    // R2: C value holds between ticks while cs_en is steady high
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_tick) && $past(cs_en) && cs_en) |-> $stable(c_bit));

    // R6: busy rises only after an enabled tick
    a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_busy) |-> $past(frame_tick && tx_en && cs_en));

    // R6: busy only while sending
    a_r6_busy_only_sending: assert property (@(posedge clk) disable iff (!rst_n)
        cs_busy |-> (state == ST_SEND));

    // R7: busy falls only at a frame boundary
    a_r7_busy_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_busy) |-> $past(frame_tick));

    // R8: tick with transmitter disabled releases busy
    a_r8_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !tx_en) |=> !cs_busy);

    // R9: C forced low with channel status disabled
    a_r9_c_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_en |-> !c_bit);
endmodule

bind cs_tx_seq cs_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .tx_en(tx_en),
    .cs_en(cs_en), .c_bit(c_bit), .cs_busy(cs_busy), .state(state)
);

// File: tb/cs_tx_seq_tb_top.sv
module cs_tx_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, wr_en, frame_tick, block_start, tx_en, cs_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        c_bit, cs_busy;

    always #5 clk = ~clk;

    cs_tx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_tick(frame_tick), .block_start(block_start),
        .tx_en(tx_en), .cs_en(cs_en), .c_bit(c_bit), .cs_busy(cs_busy)
    );

    int          checks = 0, fails = 0;
    logic [31:0] mregs [6];
    logic [31:0] msnap;
    int          mpos;
    bit          mact, mbusy;

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_c();
        return mact && cs_en && msnap[mpos % 32];
    endfunction

    // Frame-level model of one tick (uses page values before any same-cycle write)
    task automatic model_tick(bit bs);
        if (!(tx_en && cs_en)) begin
            mact = 0; mbusy = 0;
        end else if (bs) begin
            mact = 1; mpos = 0; msnap = mregs[0]; mbusy = 1;
        end else if (mact) begin
            mpos = (mpos + 1) % 192;
            if (mpos % 32 == 0) begin
                msnap = mregs[mpos / 32];
                if (mpos / 32 == 0)      mbusy = 1;
                else if (mpos / 32 == 5) mbusy = 0;
            end
        end
    endtask

    task automatic frame(bit bs, bit dowr, int a, logic [31:0] d, string req);
        @(negedge clk);
        frame_tick = 1'b1; block_start = bs;
        if (dowr) begin wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; end
        model_tick(bs);
        if (dowr) mregs[a] = d;
        @(negedge clk);
        frame_tick = 1'b0; block_start = 1'b0; wr_en = 1'b0;
        chk({req, " c_bit"}, c_bit, exp_c());
        chk({req, " busy"}, cs_busy, mbusy);
    endtask

    task automatic wr_only(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mregs[a] = d;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0C5B));
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
        frame_tick = 0; block_start = 0; tx_en = 0; cs_en = 0;
        for (int i = 0; i < 6; i++) mregs[i] = '0;
        mact = 0; mbusy = 0; mpos = 0; msnap = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset c_bit", c_bit, 1'b0);
        chk("R11 reset busy", cs_busy, 1'b0);

        // R1: fill the page with distinct values
        for (int i = 0; i < 6; i++) wr_only(i, $urandom());
        tx_en = 1; cs_en = 1;
        frame(0, 0, 0, 0, "R3 no block start");
        frame(1, 0, 0, 0, "R3 start word0");
        // R4 R6 R7: walk a full block and the wrap; rewrite word 0 in its load tick (R10)
        for (int f = 1; f < 384; f++) begin
            if (f == 192) frame(0, 1, 0, 32'hA5C3_0F96, "R10 write in load cycle");
            else if (f == 200) frame(0, 1, 4, 32'h0000_FFFF, "R10 write before load");
            else frame(0, 0, 0, 0, (f % 32 == 0) ? "R7 word load" : "R4 order");
        end
        // R2: value held between ticks, also across a page write
        repeat (3) @(negedge clk);
        chk("R2 hold", c_bit, exp_c());
        wr_only(int'(mpos / 32), 32'h1234_5678);
        chk("R2 hold after write", c_bit, exp_c());
        // R5: mid-block realignment
        for (int f = 0; f < 70; f++) frame(0, 0, 0, 0, "R4 order");
        frame(1, 0, 0, 0, "R5 realign");
        frame(0, 0, 0, 0, "R5 after realign");
        // R9: cs_en drops between ticks
        wr_only(0, 32'hFFFF_FFFF);
        frame(1, 0, 0, 0, "R6 restart");
        @(negedge clk); cs_en = 0;
        @(negedge clk);
        chk("R9 c gated", c_bit, 1'b0);
        chk("R8 busy holds until tick", cs_busy, 1'b1);
        frame(0, 0, 0, 0, "R8 stop cs_en");
        // R8: tx_en drops between ticks
        cs_en = 1;
        frame(1, 0, 0, 0, "R6 restart");
        @(negedge clk); tx_en = 0;
        @(negedge clk);
        chk("R8 busy before tick", cs_busy, 1'b1);
        frame(0, 0, 0, 0, "R8 stop tx_en");
        tx_en = 1;
        frame(0, 0, 0, 0, "R3 armed no start");

        // Random phase
        for (int f = 0; f < 2500; f++) begin
            if ($urandom_range(299) == 0) tx_en = ~tx_en;
            if ($urandom_range(299) == 0) cs_en = ~cs_en;
            if ($urandom_range(3) == 0) wr_only($urandom_range(5), $urandom());
            frame(($urandom_range(199) == 0) || (!mact && $urandom_range(7) == 0),
                  $urandom_range(3) == 0, $urandom_range(5), $urandom(), "R4 random");
        end
        finish_run();
    end
endmodule